// File: doc/BRIEF.md
# Segmented Bus Address Decoder with Boot Overlay

This block sits between a 24-bit CPU address bus and the memories and byte-wide peripherals behind it. The top five address bits pick one of 32 segments of 512 KB, and a segment table gives the device that answers there. During boot an overlay bit moves ROM images into the low part of the map and RAM higher up. Clearing the bit brings RAM down to address zero. The upper half of the map is fixed. It holds two serial-controller windows (one for read and reset, one for write), a floppy-controller window, a VIA window and a phase window.

The decoder returns read data for every cycle. Unassigned locations read as all ones. Byte-wide peripherals return their byte in the low lane. For a word access they add 0xFF in the high lane. Some windows answer only for one value of address bit 0. A word access to either serial window steps a small phase counter, and the CPU reads that counter back through the phase window. A free-running half-cycle counter, modulo 16, marks video fetch slots. A RAM access that begins inside a slot is given a stall count, in half-cycles, on `waitHalf`.

Each clock of the block is one CPU half-cycle. An access is presented for one clock with `dataStrobe` high, and the decoder answers combinationally in that clock. Register effects (phase step, overlay load) land on the following edge.

Top module: `seg_addr_decoder`

## Requirements
- R1: After reset the overlay bit is 1 and the phase counter is 1. With `dataStrobe` low no select or reset strobe is asserted and `waitHalf` is 0.
- R2: With the overlay at 1, segments below 0x600000 alternate per megabyte: the even megabytes (0x000000, 0x200000, 0x400000) are unassigned and the odd megabytes are ROM. 0x600000–0x7FFFFF is RAM.
- R3: With the overlay at 0, 0x000000–0x3FFFFF is RAM, 0x400000–0x4FFFFF is ROM and 0x500000–0x7FFFFF is unassigned.
- R4: A write with `overlayWe` high loads `overlayIn`. An access in the same clock still uses the old map, and the new map applies from the next clock.
- R5: The map from 0x800000 upward is fixed: serial read/reset at 0xA00000–0xAFFFFF, serial write at 0xC00000–0xCFFFFF, floppy at 0xE00000–0xE7FFFF, VIA at 0xF00000–0xF7FFFF, phase at 0xF80000–0xFFFFFF, and the rest unassigned. `periphSpace` is 1 exactly for addresses at or above 0xE00000.
- R6: An unassigned read returns 0xFFFF for a word access and 0x00FF for a byte access. ROM is selected only on reads, and writes to ROM or to unassigned space assert no select.
- R7: The VIA is selected only with A0=0 and the floppy controller only with A0=1. The other A0 value reads as unassigned. `regIndex` is address bits 12:9.
- R8: In the serial read window a byte access with A0=1 pulses `sccReset` and reads 0x00FF, and a byte access with A0=0 asserts `sccRdSel` and returns the serial byte.
- R9: In the serial write window a byte access with A0=1 asserts `sccWrSel`. `periphWrData` carries the CPU byte on a write and 0xFF on a read. A byte access with A0=0 is unassigned.
- R10: A word access to either serial window increments the phase counter and asserts no select. A read of the phase window returns the counter's low 3 bits, which wrap modulo 8.
- R11: The half-cycle counter starts at 0 after reset and counts every clock modulo 16. A RAM access made while the counter is c < 4 drives `waitHalf` to 4−c, and 0 otherwise. Non-RAM accesses drive 0.
- R12: A byte-wide peripheral read (serial, VIA, floppy, phase) places its byte in the low lane. The high lane is 0xFF for a word access and 0x00 for a byte access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one CPU half-cycle per period |
| rst_n | input | 1 | Active-low synchronous reset |
| overlayWe | input | 1 | Load strobe for the overlay bit |
| overlayIn | input | 1 | Value loaded into the overlay bit |
| cpuAddr | input | 24 | CPU byte address |
| dataStrobe | input | 1 | Data phase of an access is active this clock |
| isRead | input | 1 | 1 for a read cycle, 0 for a write |
| isWord | input | 1 | 1 for a word access, 0 for a byte access |
| cpuWrByte | input | 8 | Low byte of CPU write data |
| ramRdData | input | 16 | Read data from RAM |
| romRdData | input | 16 | Read data from ROM |
| sccRdData | input | 8 | Read data from the serial controller |
| viaRdData | input | 8 | Read data from the VIA |
| fdcRdData | input | 8 | Read data from the floppy controller |
| ramSel | output | 1 | RAM select |
| romSel | output | 1 | ROM select (reads only) |
| viaSel | output | 1 | VIA select |
| fdcSel | output | 1 | Floppy controller select |
| sccRdSel | output | 1 | Serial controller read select |
| sccWrSel | output | 1 | Serial controller write select |
| sccReset | output | 1 | Serial controller reset pulse |
| regIndex | output | 4 | Peripheral register index |
| periphWrData | output | 8 | Byte written to the serial controller |
| rdData | output | 16 | Read data returned to the CPU |
| waitHalf | output | 4 | RAM stall in half-cycles |
| periphSpace | output | 1 | Address lies in peripheral space |

## Verification
The bench uses the default parameters: a 4-bit half-cycle counter with 4 stall slots, a 3-bit phase counter and a register index at bits 12:9. With these values, a run of sixteen consecutive RAM accesses sees every counter residue, so each stall value and each zero-stall slot is checked. Eight phase steps are enough to reach the 3-bit wrap. The bench switches the overlay both ways, and once loads it in the same clock as an access, so that the old-map and new-map cycles can be told apart at the select outputs.

// File: rtl/segdec_pkg.sv
package segdec_pkg;

  typedef enum logic [2:0] {
    DEV_NONE, DEV_RAM, DEV_ROM, DEV_SCC_RD, DEV_SCC_WR, DEV_FDC, DEV_VIA, DEV_PHASE
  } segDev_e;

  typedef enum logic [2:0] {
    SRC_ONES, SRC_RAM, SRC_ROM, SRC_SCC, SRC_VIA, SRC_FDC, SRC_PHASE
  } rdSrc_e;

  typedef struct packed {
    logic   phaseBump;
    logic   ramAccess;
    logic   forceFf;
    rdSrc_e rdSrc;
  } ctrlStrobe_t;

  // Device answering in 512 KB segment seg, for overlay state ov.
  function automatic segDev_e segLookup(input int seg, input logic ov);
    segDev_e d;
    d = DEV_NONE;
    if (seg < 16) begin
      if (ov) begin
        if (seg >= 12) d = DEV_RAM;
        else if (((seg / 2) % 2) == 1) d = DEV_ROM;
      end else begin
        if (seg < 8) d = DEV_RAM;
        else if (seg < 10) d = DEV_ROM;
      end
    end else begin
      case (seg)
        20, 21:  d = DEV_SCC_RD;
        24, 25:  d = DEV_SCC_WR;
        28:      d = DEV_FDC;
        30:      d = DEV_VIA;
        31:      d = DEV_PHASE;
        default: d = DEV_NONE;
      endcase
    end
    return d;
  endfunction

endpackage

// File: rtl/segdec_ctrl.sv
module segdec_ctrl
  import segdec_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int SEG_BITS    = 5,
  parameter int REG_IDX_W   = 4,
  parameter int REG_LSB     = 9,
  parameter logic [ADDR_W-1:0] PERIPH_BASE = 24'hE00000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 overlay,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 dataStrobe,
  input  logic                 isRead,
  input  logic                 isWord,
  output logic                 ramSel,
  output logic                 romSel,
  output logic                 viaSel,
  output logic                 fdcSel,
  output logic                 sccRdSel,
  output logic                 sccWrSel,
  output logic                 sccReset,
  output logic [REG_IDX_W-1:0] regIndex,
  output logic                 periphSpace,
  output ctrlStrobe_t          strobes
);
  localparam int SEGMENTS = 1 << SEG_BITS;

  segDev_e segTable [SEGMENTS];
  for (genvar g = 0; g < SEGMENTS; g++) begin : g_seg
    assign segTable[g] = segLookup(g, overlay);
  end

  logic [SEG_BITS-1:0] segIdx;
  segDev_e             dev;
  logic                a0;

  assign segIdx      = addr[ADDR_W-1 -: SEG_BITS];
  assign dev         = segTable[segIdx];
  assign a0          = addr[0];
  assign regIndex    = addr[REG_LSB +: REG_IDX_W];
  assign periphSpace = (addr >= PERIPH_BASE);

  always_comb begin
    ramSel = 1'b0; romSel = 1'b0; viaSel = 1'b0; fdcSel = 1'b0;
    sccRdSel = 1'b0; sccWrSel = 1'b0; sccReset = 1'b0;
    strobes = '{phaseBump: 1'b0, ramAccess: 1'b0, forceFf: 1'b0, rdSrc: SRC_ONES};
    if (dataStrobe) begin
      case (dev)
        DEV_RAM: begin
          ramSel = 1'b1;
          strobes.ramAccess = 1'b1;
          strobes.rdSrc = SRC_RAM;
        end
        DEV_ROM: begin
          romSel = isRead;
          strobes.rdSrc = SRC_ROM;
        end
        DEV_VIA: if (!a0) begin
          viaSel = 1'b1;
          strobes.rdSrc = SRC_VIA;
        end
        DEV_FDC: if (a0) begin
          fdcSel = 1'b1;
          strobes.rdSrc = SRC_FDC;
        end
        DEV_SCC_RD: begin
          if (isWord) strobes.phaseBump = 1'b1;
          else if (a0) sccReset = 1'b1;
          else begin
            sccRdSel = 1'b1;
            strobes.rdSrc = SRC_SCC;
          end
        end
        DEV_SCC_WR: begin
          if (isWord) strobes.phaseBump = 1'b1;
          else if (a0) begin
            sccWrSel = 1'b1;
            strobes.forceFf = isRead;
          end
        end
        DEV_PHASE: strobes.rdSrc = SRC_PHASE;
        default: ;
      endcase
    end
  end

  // R5: at most one device select at a time
  a_r5_onehot_sel: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ramSel, romSel, viaSel, fdcSel, sccRdSel, sccWrSel, sccReset}));
  // R6: ROM never selected for a write
  a_r6_rom_read_only: assert property (@(posedge clk) disable iff (!rst_n)
    romSel |-> isRead);
  // R7: lane qualification of VIA and floppy
  a_r7_via_even: assert property (@(posedge clk) disable iff (!rst_n)
    viaSel |-> !addr[0]);
  a_r7_fdc_odd: assert property (@(posedge clk) disable iff (!rst_n)
    fdcSel |-> addr[0]);
  // R8: serial reset only from byte cycles
  a_r8_reset_byte: assert property (@(posedge clk) disable iff (!rst_n)
    sccReset |-> !isWord);
endmodule

// File: rtl/segdec_dp.sv
module segdec_dp
  import segdec_pkg::*;
#(
  parameter int SUB_W       = 4,
  parameter int STALL_SLOTS = 4,
  parameter int PHASE_W     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              overlayWe,
  input  logic              overlayIn,
  input  ctrlStrobe_t       strobes,
  input  logic              isWord,
  input  logic [7:0]        cpuWrByte,
  input  logic [15:0]       ramRdData,
  input  logic [15:0]       romRdData,
  input  logic [7:0]        sccRdData,
  input  logic [7:0]        viaRdData,
  input  logic [7:0]        fdcRdData,
  output logic              overlay,
  output logic [15:0]       rdData,
  output logic [SUB_W-1:0]  waitHalf,
  output logic [7:0]        periphWrData
);
  localparam logic [SUB_W-1:0] SLOTS = SUB_W'(STALL_SLOTS);

  logic [PHASE_W-1:0] phase;
  logic [SUB_W-1:0]   subCycle;
  logic [7:0]         hiLane;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      overlay  <= 1'b1;
      phase    <= PHASE_W'(1);
      subCycle <= '0;
    end else begin
      subCycle <= subCycle + 1'b1;
      if (overlayWe) overlay <= overlayIn;
      if (strobes.phaseBump) phase <= phase + 1'b1;
    end
  end

  assign waitHalf     = (strobes.ramAccess && subCycle < SLOTS) ? SLOTS - subCycle : '0;
  assign hiLane       = isWord ? 8'hFF : 8'h00;
  assign periphWrData = strobes.forceFf ? 8'hFF : cpuWrByte;

  always_comb begin
    case (strobes.rdSrc)
      SRC_RAM:   rdData = ramRdData;
      SRC_ROM:   rdData = romRdData;
      SRC_SCC:   rdData = {hiLane, sccRdData};
      SRC_VIA:   rdData = {hiLane, viaRdData};
      SRC_FDC:   rdData = {hiLane, fdcRdData};
      SRC_PHASE: rdData = {hiLane, 5'b0, phase[2:0]};
      default:   rdData = {hiLane, 8'hFF};
    endcase
  end

  // R11: stall never exceeds the slot count
  a_r11_wait_bound: assert property (@(posedge clk) disable iff (!rst_n)
    waitHalf <= SLOTS);
  // R11: stalls only for RAM cycles
  a_r11_wait_ram_only: assert property (@(posedge clk) disable iff (!rst_n)
    (waitHalf != '0) |-> strobes.ramAccess);
  // R10: phase moves only by single steps
  a_r10_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != $past(phase)) |-> (phase == $past(phase) + 1'b1));
  // R4: overlay holds without a load
  a_r4_overlay_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !overlayWe |=> $stable(overlay));
endmodule

// File: rtl/seg_addr_decoder.sv
module seg_addr_decoder
  import segdec_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int SEG_BITS    = 5,
  parameter int REG_IDX_W   = 4,
  parameter int REG_LSB     = 9,
  parameter int SUB_W       = 4,
  parameter int STALL_SLOTS = 4,
  parameter int PHASE_W     = 3,
  parameter logic [ADDR_W-1:0] PERIPH_BASE = 24'hE00000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 overlayWe,
  input  logic                 overlayIn,
  input  logic [ADDR_W-1:0]    cpuAddr,
  input  logic                 dataStrobe,
  input  logic                 isRead,
  input  logic                 isWord,
  input  logic [7:0]           cpuWrByte,
  input  logic [15:0]          ramRdData,
  input  logic [15:0]          romRdData,
  input  logic [7:0]           sccRdData,
  input  logic [7:0]           viaRdData,
  input  logic [7:0]           fdcRdData,
  output logic                 ramSel,
  output logic                 romSel,
  output logic                 viaSel,
  output logic                 fdcSel,
  output logic                 sccRdSel,
  output logic                 sccWrSel,
  output logic                 sccReset,
  output logic [REG_IDX_W-1:0] regIndex,
  output logic [7:0]           periphWrData,
  output logic [15:0]          rdData,
  output logic [SUB_W-1:0]     waitHalf,
  output logic                 periphSpace
);
  ctrlStrobe_t strobes;
  logic        overlay;

  segdec_ctrl #(
    .ADDR_W(ADDR_W), .SEG_BITS(SEG_BITS), .REG_IDX_W(REG_IDX_W),
    .REG_LSB(REG_LSB), .PERIPH_BASE(PERIPH_BASE)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .overlay(overlay), .addr(cpuAddr),
    .dataStrobe(dataStrobe), .isRead(isRead), .isWord(isWord),
    .ramSel(ramSel), .romSel(romSel), .viaSel(viaSel), .fdcSel(fdcSel),
    .sccRdSel(sccRdSel), .sccWrSel(sccWrSel), .sccReset(sccReset),
    .regIndex(regIndex), .periphSpace(periphSpace), .strobes(strobes)
  );

  segdec_dp #(
    .SUB_W(SUB_W), .STALL_SLOTS(STALL_SLOTS), .PHASE_W(PHASE_W)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .overlayWe(overlayWe), .overlayIn(overlayIn),
    .strobes(strobes), .isWord(isWord), .cpuWrByte(cpuWrByte),
    .ramRdData(ramRdData), .romRdData(romRdData), .sccRdData(sccRdData),
    .viaRdData(viaRdData), .fdcRdData(fdcRdData), .overlay(overlay),
    .rdData(rdData), .waitHalf(waitHalf), .periphWrData(periphWrData)
  );
endmodule

// File: tb/seg_addr_decoder_bench.sv
`timescale 1ns/100ps
module seg_addr_decoder_bench;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        overlayWe = 1'b0, overlayIn = 1'b0;
  logic [23:0] cpuAddr = '0;
  logic        dataStrobe = 1'b0, isRead = 1'b1, isWord = 1'b0;
  logic [7:0]  cpuWrByte = '0;
  logic [15:0] ramRdData = 16'h1234, romRdData = 16'hBEEF;
  logic [7:0]  sccRdData = 8'h5A, viaRdData = 8'hC3, fdcRdData = 8'h96;
  logic ramSel, romSel, viaSel, fdcSel, sccRdSel, sccWrSel, sccReset, periphSpace;
  logic [3:0]  regIndex, waitHalf;
  logic [7:0]  periphWrData;
  logic [15:0] rdData;

  seg_addr_decoder u_seg_addr_decoder (.*);

  localparam logic [6:0] S_NONE = 7'b0000000, S_RAM = 7'b1000000, S_ROM = 7'b0100000,
    S_VIA = 7'b0010000, S_FDC = 7'b0001000, S_SRD = 7'b0000100, S_SWR = 7'b0000010,
    S_RST = 7'b0000001;

  typedef struct packed {
    logic [23:0] addr;
    logic [6:0]  sel;
    logic [15:0] rd;
    logic        chkRd;
    logic [3:0]  wt;
    logic        per;
    logic [3:0]  reg_;
    logic [7:0]  pwd;
  } item_t;

  item_t q[$];
  string tagQ[$];
  int nChk = 0, nFail = 0, cyc = 0, expPhase = 1;
  bit done = 0;

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  task automatic acc(input logic [23:0] a, input logic rd, input logic wd,
                     input logic [7:0] wb, input logic [6:0] es, input logic [15:0] er,
                     input logic chk, input string tag,
                     input logic stb = 1'b1, input logic ow = 1'b0, input logic ov = 1'b0);
    item_t it;
    int s;
    @(negedge clk);
    cpuAddr = a; isRead = rd; isWord = wd; cpuWrByte = wb; dataStrobe = stb;
    overlayWe = ow; overlayIn = ov;
    s = cyc % 16;
    it.addr = a; it.sel = es; it.rd = er; it.chkRd = chk;
    it.wt = (es == S_RAM && s < 4) ? 4'(4 - s) : 4'd0;
    it.per = (a >= 24'hE00000);
    it.reg_ = a[12:9];
    it.pwd = (es == S_SWR && rd) ? 8'hFF : wb;
    q.push_back(it);
    tagQ.push_back(tag);
  endtask

  // monitor
  always begin
    item_t it;
    string tg;
    logic [6:0] as;
    bit ok;
    @(negedge clk);
    #2;
    if (q.size() > 0) begin
      it = q.pop_front();
      tg = tagQ.pop_front();
      as = {ramSel, romSel, viaSel, fdcSel, sccRdSel, sccWrSel, sccReset};
      ok = (as == it.sel) && (waitHalf == it.wt) && (periphSpace == it.per) &&
           (regIndex == it.reg_) && (periphWrData == it.pwd) &&
           (!it.chkRd || rdData == it.rd);
      nChk++;
      if (!ok) begin
        nFail++;
        $display("FAIL %s addr=%h sel=%b exp %b rd=%h exp %h wait=%0d exp %0d per=%b exp %b reg=%0d exp %0d pwd=%h exp %h",
                 tg, it.addr, as, it.sel, rdData, it.rd, waitHalf, it.wt, periphSpace, it.per,
                 regIndex, it.reg_, periphWrData, it.pwd);
      end
    end
  end

  task automatic summary();
    $display("  %0d/%0d checks passed", nChk - nFail, nChk);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      nChk++; nFail++;
      $display("FAIL watchdog expired: actual running, expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1 reset state
    acc(24'h000000, 1, 0, 8'h00, S_NONE, 16'h0000, 0, "R1 idle", 1'b0);
    acc(24'hF80000, 1, 0, 8'h00, S_NONE, 16'h0001, 1, "R1 phase reset");
    // R2 overlay-on map
    acc(24'h000000, 1, 0, 8'h00, S_NONE, 16'h00FF, 1, "R2 even MB unassigned");
    acc(24'h100000, 1, 1, 8'h00, S_ROM,  16'hBEEF, 1, "R2 ROM at 1MB");
    acc(24'h500002, 1, 1, 8'h00, S_ROM,  16'hBEEF, 1, "R2 ROM at 5MB");
    acc(24'h400000, 1, 1, 8'h00, S_NONE, 16'hFFFF, 1, "R2 4MB unassigned");
    acc(24'h600000, 1, 1, 8'h00, S_RAM,  16'h1234, 1, "R2 RAM low");
    acc(24'h7FFFFE, 1, 1, 8'h00, S_RAM,  16'h1234, 1, "R2 RAM top");
    // R6 ROM write ignored
    acc(24'h300000, 0, 1, 8'hAA, S_NONE, 16'h0000, 0, "R6 ROM write");
    // R4 load with simultaneous access uses old map
    acc(24'h000000, 1, 1, 8'h00, S_NONE, 16'hFFFF, 1, "R4 same-cycle old map", 1'b1, 1'b1, 1'b0);
    acc(24'h000000, 1, 1, 8'h00, S_RAM,  16'h1234, 1, "R4 next-cycle new map");
    // R3 overlay-off map
    acc(24'h3FFFFE, 1, 1, 8'h00, S_RAM,  16'h1234, 1, "R3 RAM top");
    acc(24'h400000, 1, 1, 8'h00, S_ROM,  16'hBEEF, 1, "R3 ROM");
    acc(24'h4FFFFF, 1, 0, 8'h00, S_ROM,  16'hBEEF, 1, "R3 ROM end");
    acc(24'h500000, 1, 1, 8'h00, S_NONE, 16'hFFFF, 1, "R3 unassigned");
    acc(24'h7FFFFE, 1, 1, 8'h00, S_NONE, 16'hFFFF, 1, "R3 unassigned top");
    // R5 fixed upper map, R6 unassigned
    acc(24'h800000, 1, 1, 8'h00, S_NONE, 16'hFFFF, 1, "R5 0x800000");
    acc(24'h900000, 0, 0, 8'h11, S_NONE, 16'h0000, 0, "R6 unassigned write");
    acc(24'hDFFFFF, 1, 0, 8'h00, S_NONE, 16'h00FF, 1, "R5 below periph");
    acc(24'hE80000, 1, 0, 8'h00, S_NONE, 16'h00FF, 1, "R5 0xE80000");
    // R8 serial read window
    acc(24'hA00000, 1, 0, 8'h00, S_SRD,  16'h005A, 1, "R8 serial read");
    acc(24'hA00001, 1, 0, 8'h00, S_RST,  16'h00FF, 1, "R8 serial reset");
    acc(24'hA00000, 0, 1, 8'h00, S_NONE, 16'h0000, 0, "R10 word bump rd window");
    expPhase++;
    // R9 serial write window
    acc(24'hC00001, 0, 0, 8'h3C, S_SWR,  16'h0000, 0, "R9 serial write");
    acc(24'hC00001, 1, 0, 8'h3C, S_SWR,  16'h00FF, 1, "R9 serial write on read");
    acc(24'hC00000, 0, 0, 8'h77, S_NONE, 16'h0000, 0, "R9 even lane unassigned");
    acc(24'hC00000, 1, 1, 8'h00, S_NONE, 16'h0000, 0, "R10 word bump wr window");
    expPhase++;
    acc(24'hF80000, 1, 1, 8'h00, S_NONE, {8'hFF, 8'(expPhase % 8)}, 1, "R10 R12 phase word read");
    // R7 VIA / floppy, R12 lanes
    acc(24'hF00A00, 1, 0, 8'h00, S_VIA,  16'h00C3, 1, "R7 VIA byte");
    acc(24'hF01200, 1, 1, 8'h00, S_VIA,  16'hFFC3, 1, "R12 VIA word");
    acc(24'hF00001, 1, 0, 8'h00, S_NONE, 16'h00FF, 1, "R7 VIA odd unassigned");
    acc(24'hE00601, 1, 0, 8'h00, S_FDC,  16'h0096, 1, "R7 floppy odd");
    acc(24'hE00000, 1, 0, 8'h00, S_NONE, 16'h00FF, 1, "R7 floppy even unassigned");
    // R10 wrap
    for (int i = 0; i < 6; i++) begin
      acc((i % 2) ? 24'hC00000 : 24'hA00000, 0, 1, 8'h00, S_NONE, 16'h0000, 0, "R10 bump");
      expPhase++;
    end
    acc(24'hF80000, 1, 0, 8'h00, S_NONE, {8'h00, 8'(expPhase % 8)}, 1, "R10 phase wrap");
    // R11 wait states over all residues
    for (int i = 0; i < 16; i++)
      acc(24'h000100, (i % 3) != 0, 1, 8'h00, S_RAM, 16'h1234, 0, "R11 wait");
    acc(24'h400000, 1, 1, 8'h00, S_ROM, 16'hBEEF, 1, "R11 ROM no wait");
    // R4 back to overlay on
    acc(24'h000000, 1, 0, 8'h00, S_NONE, 16'h0000, 0, "R4 load idle", 1'b0, 1'b1, 1'b1);
    acc(24'h000000, 1, 1, 8'h00, S_NONE, 16'hFFFF, 1, "R4 overlay restored");
    acc(24'h600000, 1, 1, 8'h00, S_RAM,  16'h1234, 1, "R4 RAM high again");
    @(negedge clk) dataStrobe = 1'b0; overlayWe = 1'b0;
    repeat (3) @(posedge clk);
    if (!done) begin
      done = 1;
      summary();
      $finish;
    end
  end
endmodule